// File: doc/BRIEF.md
# Entropy Seed Register Access Unit

This unit serves one read-write-only control/status register that hands entropy to software. It sits inside a processor's CSR file and looks at every CSR access. If the access targets the seed address, the unit decides whether the access is allowed. It bases that decision on the extension enable, the instruction form, the current privilege level, the virtualization flag and two enable bits in the machine security configuration word. It then returns a response one clock later.

An allowed access returns a 32-bit word. The word carries a two-bit operational status in its top bits. When the status says entropy is valid, the low sixteen bits hold a fresh sample. That sample comes from a one-entry holding register, which is filled by an external entropy source over a valid/ready handshake. A successful read empties the holding register, so no sample is ever handed out twice. The source also has a fault line. Once the fault is seen, the unit reports a dead source until reset. A disallowed access produces either an illegal-instruction indication or a virtual-instruction indication. The trap itself is taken elsewhere in the pipeline.

Top module: `seed_csr_unit`

## Requirements
- R1: Only an access with address 12'h015 gets a response: rsp_valid rises in the cycle after such a request. An access to any other address gets no response and does not consume a held sample.
- R2: The status field is rsp_rdata[31:30]. The codes are 2'b00 self-test, 2'b01 waiting, 2'b10 sample valid and 2'b11 dead. Bits 29:16 always read as zero.
- R3: An allowed read that finds a held sample returns status 2'b10 with the sample in bits 15:0, and it empties the holding register. If no sample is held, the read returns 2'b01 with bits 15:0 at zero.
- R4: A read-only form (acc_rw = 0) gives rsp_illegal, returns zero data and consumes nothing.
- R5: When ext_en is 0, every access to the seed address gives rsp_illegal.
- R6: When not virtualized, the privilege is encoded as 2'b11 machine, 2'b01 supervisor and 2'b00 user, and 2'b10 is reserved. Machine mode is always allowed. Supervisor mode needs sec_cfg[9], and user mode needs sec_cfg[8]. Every other case, including the reserved code, is illegal.
- R7: When virt = 1 and the privilege is not machine, the access gives rsp_virt_fault if sec_cfg[9] is set, and rsp_illegal otherwise.
- R8: A cycle with es_fault = 1 makes every later allowed read return 2'b11 with zero data, until reset.
- R9: For BIST_CYCLES cycles after reset, allowed reads return status 2'b00 with zero data and consume nothing.
- R10: rsp_illegal and rsp_virt_fault are never high together, and a trapping response carries zero data.
- R11: wr_data has no effect on any response.
- R12: es_ready is high exactly when the holding register is empty. A sample is captured on a clock edge where es_valid and es_ready are both high. After reset es_ready is 1 and rsp_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A CSR access is presented this cycle |
| csr_addr | input | 12 | CSR address of the access |
| acc_rw | input | 1 | 1 = read-write form, 0 = read-only form |
| wr_data | input | 32 | Write operand (ignored) |
| priv | input | 2 | Current privilege level |
| virt | input | 1 | Virtualization active |
| ext_en | input | 1 | Entropy extension enabled |
| sec_cfg | input | 16 | Machine security configuration bits |
| es_valid | input | 1 | Entropy source offers a sample |
| es_data | input | 16 | Offered sample |
| es_fault | input | 1 | Entropy source failure |
| es_ready | output | 1 | Holding register can take a sample |
| rsp_valid | output | 1 | Response for a seed access |
| rsp_rdata | output | 32 | Status-tagged read value |
| rsp_illegal | output | 1 | Illegal-instruction indication |
| rsp_virt_fault | output | 1 | Virtual-instruction indication |

## Verification
The bench runs the full matrix of privilege, virtualization and the two enable bits, with a sample held for every access. A wrong decision order would show up here, for example granting a virtualized supervisor or giving a virtual fault where an illegal one belongs. The bench reads twice without refilling and also reads during self-test. A design that forgets to consume would repeat a sample, and one that consumes during self-test would lose one. Read-only forms, foreign addresses and accesses with varied write data are each followed by a normal read. Those reads expose any trapping or stray access that drained the buffer. After a source fault, the bench checks that the dead status sticks, because a design that re-sampled the fault line would return to waiting.

// File: rtl/seed_csr_pkg.sv
`timescale 1ns/1ps
package seed_csr_pkg;

    localparam logic [11:0] SEED_ADDR = 12'h015;
    localparam int          ENT_W     = 16;
    localparam int          RD_W      = 32;
    localparam int          USEED_BIT = 8;
    localparam int          SSEED_BIT = 9;

    typedef enum logic [1:0] {
        ST_BIST = 2'b00,
        ST_WAIT = 2'b01,
        ST_ES16 = 2'b10,
        ST_DEAD = 2'b11
    } seed_status_e;

    typedef enum logic [1:0] {
        PRIV_U    = 2'b00,
        PRIV_S    = 2'b01,
        PRIV_RSVD = 2'b10,
        PRIV_M    = 2'b11
    } priv_e;

    typedef enum logic [1:0] {
        VERD_OK      = 2'b00,
        VERD_ILLEGAL = 2'b01,
        VERD_VIRT    = 2'b10
    } verdict_e;

    typedef struct packed {
        seed_status_e      status;
        logic [ENT_W-1:0]  sample;
    } seed_word_t;

    function automatic logic [RD_W-1:0] pack_seed(input seed_word_t w);
        return {w.status, {(RD_W-2-ENT_W){1'b0}}, w.sample};
    endfunction

endpackage

// File: rtl/seed_access_check.sv
`timescale 1ns/1ps
module seed_access_check
    import seed_csr_pkg::*;
(
    input  logic       ext_en,
    input  logic       rw_form,
    input  logic [1:0] priv,
    input  logic       virt,
    input  logic       useed,
    input  logic       sseed,
    output verdict_e   verdict
);

    always_comb begin
        verdict = VERD_ILLEGAL;
        if (!ext_en || !rw_form) begin
            verdict = VERD_ILLEGAL;
        end else if (virt && priv != PRIV_M) begin
            verdict = sseed ? VERD_VIRT : VERD_ILLEGAL;
        end else begin
            case (priv)
                PRIV_M:  verdict = VERD_OK;
                PRIV_S:  verdict = sseed ? VERD_OK : VERD_ILLEGAL;
                PRIV_U:  verdict = useed ? VERD_OK : VERD_ILLEGAL;
                default: verdict = VERD_ILLEGAL;
            endcase
        end
    end

    // R4
    always_comb begin
        if (!rw_form) rd_only_traps_chk: assert (verdict == VERD_ILLEGAL);
    end

endmodule

// File: rtl/seed_entropy_buf.sv
`timescale 1ns/1ps
module seed_entropy_buf
    import seed_csr_pkg::*;
#(
    parameter int BIST_CYCLES = 8
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              grant,
    input  logic              es_valid,
    input  logic [ENT_W-1:0]  es_data,
    input  logic              es_fault,
    output logic              es_ready,
    output seed_word_t        word
);

    localparam int CNT_W = (BIST_CYCLES < 2) ? 1 : $clog2(BIST_CYCLES + 1);

    logic [CNT_W-1:0] bist_cnt;
    logic             full_q;
    logic             dead_q;
    logic [ENT_W-1:0] data_q;
    logic             take;
    logic             load;

    always_comb begin
        if (dead_q)              word.status = ST_DEAD;
        else if (bist_cnt != '0) word.status = ST_BIST;
        else if (full_q)         word.status = ST_ES16;
        else                     word.status = ST_WAIT;
        word.sample = (word.status == ST_ES16) ? data_q : '0;
    end

    assign es_ready = !full_q;
    assign take     = grant && (word.status == ST_ES16);
    assign load     = es_valid && !full_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bist_cnt <= CNT_W'(BIST_CYCLES);
            full_q   <= 1'b0;
            dead_q   <= 1'b0;
            data_q   <= '0;
        end else begin
            if (bist_cnt != '0) bist_cnt <= bist_cnt - 1'b1;
            if (es_fault)       dead_q   <= 1'b1;
            if (take) begin
                full_q <= 1'b0;
            end else if (load) begin
                full_q <= 1'b1;
                data_q <= es_data;
            end
        end
    end

    // R8
    dead_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        dead_q |=> dead_q);

    // R3
    take_empties_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> !full_q);

    // R12
    capture_chk: assert property (@(posedge clk) disable iff (rst)
        (es_valid && es_ready) |=> (full_q && data_q == $past(es_data)));

endmodule

// File: rtl/seed_csr_unit.sv
`timescale 1ns/1ps
module seed_csr_unit
    import seed_csr_pkg::*;
#(
    parameter int BIST_CYCLES = 8
)(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [11:0] csr_addr,
    input  logic        acc_rw,
    input  logic [31:0] wr_data,
    input  logic [1:0]  priv,
    input  logic        virt,
    input  logic        ext_en,
    input  logic [15:0] sec_cfg,
    input  logic        es_valid,
    input  logic [15:0] es_data,
    input  logic        es_fault,
    output logic        es_ready,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata,
    output logic        rsp_illegal,
    output logic        rsp_virt_fault
);

    logic       sel;
    logic       grant;
    verdict_e   verdict;
    seed_word_t word;
    logic       unused_bits;

    assign unused_bits = ^{wr_data, sec_cfg[15:SSEED_BIT+1], sec_cfg[USEED_BIT-1:0]};
    assign sel   = req_valid && (csr_addr == SEED_ADDR);
    assign grant = sel && (verdict == VERD_OK);

    seed_access_check u_check (
        .ext_en  (ext_en),
        .rw_form (acc_rw),
        .priv    (priv),
        .virt    (virt),
        .useed   (sec_cfg[USEED_BIT]),
        .sseed   (sec_cfg[SSEED_BIT]),
        .verdict (verdict)
    );

    seed_entropy_buf #(.BIST_CYCLES(BIST_CYCLES)) u_buf (
        .clk      (clk),
        .rst      (rst),
        .grant    (grant),
        .es_valid (es_valid),
        .es_data  (es_data),
        .es_fault (es_fault),
        .es_ready (es_ready),
        .word     (word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid      <= 1'b0;
            rsp_illegal    <= 1'b0;
            rsp_virt_fault <= 1'b0;
            rsp_rdata      <= '0;
        end else begin
            rsp_valid      <= sel;
            rsp_illegal    <= sel && (verdict == VERD_ILLEGAL);
            rsp_virt_fault <= sel && (verdict == VERD_VIRT);
            rsp_rdata      <= grant ? pack_seed(word) : '0;
        end
    end

    // R10
    excl_trap_chk: assert property (@(posedge clk) disable iff (rst)
        !(rsp_illegal && rsp_virt_fault));

    // R10
    trap_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_illegal || rsp_virt_fault) |-> (rsp_rdata == '0));

    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_rdata[29:16] == '0));

    // R8
    dead_no_data_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_rdata[31:30] == 2'b11) |-> (rsp_rdata[15:0] == '0));

    // R1
    no_stray_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && csr_addr == SEED_ADDR) |=> !rsp_valid);

endmodule

// File: tb/test_seed_csr_unit.sv
`timescale 1ns/1ps
module test_seed_csr_unit;

    localparam int BIST = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [11:0] csr_addr = '0;
    logic        acc_rw = 1'b1;
    logic [31:0] wr_data = '0;
    logic [1:0]  priv = 2'b11;
    logic        virt = 1'b0;
    logic        ext_en = 1'b1;
    logic [15:0] sec_cfg = '0;
    logic        es_valid = 1'b0;
    logic [15:0] es_data = '0;
    logic        es_fault = 1'b0;
    logic        es_ready;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rsp_illegal;
    logic        rsp_virt_fault;

    seed_csr_unit #(.BIST_CYCLES(BIST)) i_seed_csr_unit (
        .clk(clk), .rst(rst), .req_valid(req_valid), .csr_addr(csr_addr),
        .acc_rw(acc_rw), .wr_data(wr_data), .priv(priv), .virt(virt),
        .ext_en(ext_en), .sec_cfg(sec_cfg), .es_valid(es_valid),
        .es_data(es_data), .es_fault(es_fault), .es_ready(es_ready),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_illegal(rsp_illegal), .rsp_virt_fault(rsp_virt_fault)
    );

    always #2 clk = ~clk;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;
    string tag   = "R12";

    // behavioural model state
    int          m_bist = BIST;
    bit          m_full = 0;
    bit          m_dead = 0;
    logic [15:0] m_data = '0;
    logic [15:0] seen_q[$];

    logic        e_valid, e_ill, e_vf, e_ready;
    logic [31:0] e_rdata;

    task automatic cmp(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic step();
        bit   sel, ok;
        int   st;
        sel = req_valid && csr_addr == 12'h015;
        // access decision
        if (!ext_en || !acc_rw) begin ok = 0; e_vf = 0; end
        else if (virt && priv != 2'b11) begin ok = 0; e_vf = sec_cfg[9]; end
        else begin
            e_vf = 0;
            ok = (priv == 2'b11) || (priv == 2'b01 && sec_cfg[9]) || (priv == 2'b00 && sec_cfg[8]);
        end
        st = m_dead ? 3 : (m_bist > 0 ? 0 : (m_full ? 2 : 1));
        e_valid = sel;
        e_vf    = sel && e_vf;
        e_ill   = sel && !ok && !e_vf;
        e_rdata = (sel && ok) ? {st[1:0], 14'b0, (st == 2) ? m_data : 16'h0} : 32'h0;
        if (rst) begin
            m_bist = BIST; m_full = 0; m_dead = 0;
            e_valid = 0; e_ill = 0; e_vf = 0; e_rdata = 0;
        end else begin
            if (m_bist > 0) m_bist--;
            if (es_fault) m_dead = 1;
            if (sel && ok && st == 2) begin
                if (m_data inside {seen_q}) begin
                    n_cmp++; n_bad++;
                    $display("FAIL R3 repeated sample: actual %h expected fresh", m_data);
                end
                seen_q.push_back(m_data);
                m_full = 0;
            end else if (es_valid && !m_full) begin
                m_full = 1; m_data = es_data;
            end
        end
        e_ready = !m_full;
        @(posedge clk);
        #1;
        cmp("rsp_valid", 32'(rsp_valid), 32'(e_valid));
        cmp("rsp_illegal", 32'(rsp_illegal), 32'(e_ill));
        cmp("rsp_virt_fault", 32'(rsp_virt_fault), 32'(e_vf));
        cmp("rsp_rdata", rsp_rdata, e_rdata);
        cmp("es_ready", 32'(es_ready), 32'(e_ready));
    endtask

    logic [15:0] next_sample = 16'h1000;

    task automatic idle();
        req_valid = 0; es_valid = 0; es_fault = 0;
    endtask

    task automatic fill();
        idle(); es_valid = 1; es_data = next_sample; next_sample++;
        step(); es_valid = 0;
    endtask

    task automatic rd(input bit rw);
        req_valid = 1; csr_addr = 12'h015; acc_rw = rw;
        step(); req_valid = 0;
    endtask

    task automatic do_reset();
        idle(); rst = 1; step(); step(); rst = 0;
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #1;
        tag = "R12"; do_reset();
        tag = "R9";
        fill();
        for (int i = 0; i < BIST; i++) begin wr_data = 32'(i); priv = 2'b11; rd(1); end
        tag = "R3";
        rd(1); rd(1);
        fill(); rd(1);
        tag = "R1";
        fill();
        req_valid = 1; csr_addr = 12'h014; step();
        csr_addr = 12'h115; step();
        rd(1);
        tag = "R4";
        fill(); rd(0); rd(1);
        tag = "R5";
        fill(); ext_en = 0; rd(1); ext_en = 1; rd(1);
        for (int p = 0; p < 4; p++)
            for (int c = 0; c < 4; c++)
                for (int v = 0; v < 2; v++) begin
                    tag = v ? "R7" : "R6";
                    fill();
                    priv = 2'(p); virt = v[0]; sec_cfg = 16'(c) << 8;
                    rd(1);
                    priv = 2'b11; virt = 0; sec_cfg = 0;
                    rd(1);
                end
        tag = "R11";
        for (int i = 0; i < 6; i++) begin
            fill(); wr_data = $urandom; rd(1);
            wr_data = ~wr_data; rd(1);
        end
        tag = "R10";
        for (int i = 0; i < 400; i++) begin
            req_valid = $urandom_range(0, 1);
            csr_addr  = ($urandom_range(0, 7) == 0) ? 12'h3a0 : 12'h015;
            acc_rw    = ($urandom_range(0, 3) != 0);
            priv      = 2'($urandom);
            virt      = ($urandom_range(0, 3) == 0);
            ext_en    = ($urandom_range(0, 7) != 0);
            sec_cfg   = 16'($urandom);
            wr_data   = $urandom;
            es_valid  = $urandom_range(0, 1);
            es_data   = next_sample; next_sample++;
            step();
        end
        idle(); ext_en = 1; virt = 0; priv = 2'b11; acc_rw = 1;
        tag = "R2";
        fill(); rd(1); rd(1);
        tag = "R8";
        fill(); es_fault = 1; step(); es_fault = 0;
        rd(1); fill(); rd(1); rd(1);
        tag = "R12";
        do_reset();
        for (int i = 0; i < BIST; i++) step();
        fill(); rd(1);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule